// File: doc/BRIEF.md
# Multi-page-size lockable translation buffer

This block is a small fully associative translation buffer. Every slot maps a virtual page number to a physical page number, and every slot carries its own page size: 8K, 64K, 512K or 4M. A lookup presents a virtual address and gets back, in the same cycle, a hit flag, the physical address and three attribute bits. The attribute bits are two cacheability flags, one for physically indexed caches and one for virtually indexed caches, and a side-effect flag. The buffer stores these bits and hands them on; it never acts on them.

Loads write a new translation into a slot picked by a replacement policy. The policy looks first for an empty slot and then for one that has not been used recently, and it never takes a valid locked slot. A diagnostic port reads and writes the per-slot used bit and shows the size code. A data-access port reads back everything stored in a slot, including the low page-number bits that a large page ignores during translation.

Top module: `mpt_tlb`

## Requirements
- R1: After reset every slot is invalid with its lock and used bits clear. Every lookup misses, the data-access port reports valid 0, and the diagnostic read is 0.
- R2: The size code of a slot sets how many low bits of the virtual page number (virtual address bits 13 and up) are left out of the tag compare. Code 000 leaves none out (8K). Code 001 leaves out 3 bits (64K), code 011 leaves out 6 bits (512K) and code 111 leaves out 9 bits (4M). Any other code behaves as 8K. A slot can only hit while it is valid.
- R3: On a hit, physical address bits 12:0 equal virtual address bits 12:0. The physical page number bits that the size leaves out are taken from the virtual page number, and the remaining bits come from the stored page number. The two cacheability bits and the side-effect bit of the hitting slot appear unchanged. On a miss the address and attribute outputs are 0.
- R4: When more than one slot hits, `lk_multi` is 1, `lk_hit` is 1 and the outputs come from the lowest-indexed hitting slot. With one hit or none, `lk_multi` is 0.
- R5: A lookup hit sets the used bit of the slot it reports at the next clock edge.
- R6: A load writes the slot that the policy picks, with its valid bit taken from `ld_valid` and its used bit set. If any slot is invalid, the lowest-indexed invalid slot is picked, whatever its lock bit.
- R7: When every slot is valid, the lowest-indexed slot that is unlocked and has its used bit clear is picked. A valid locked slot is never picked while an unlocked one exists.
- R8: When every slot is valid and every unlocked slot has its used bit set, the load clears the used bits of all unlocked slots and picks the lowest-indexed unlocked slot.
- R9: When every slot is valid and locked, the load writes the last slot.
- R10: The diagnostic read word has the used bit at bit 0, the size code at bits 3:1 and again at bits 6:4, and 0 in every other bit. A diagnostic write changes only the used bit, from write bit 0. The size code cannot be changed through this port.
- R11: The data-access read returns the stored valid, lock, size, virtual page number and attribute bits. It returns the full stored physical page number, including the low bits a large page ignores. The software-defined field accepts any load value and always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_va | input | VA_W | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit |
| lk_multi | output | 1 | More than one slot hit |
| lk_pa | output | PA_W | Translated physical address |
| lk_cp | output | 1 | Physically-indexed cacheable bit of the hit |
| lk_cv | output | 1 | Virtually-indexed cacheable bit of the hit |
| lk_e | output | 1 | Side-effect bit of the hit |
| ld_en | input | 1 | Load a translation this cycle |
| ld_valid | input | 1 | Valid bit of the loaded translation |
| ld_vpn | input | VA_W-13 | Virtual page number to load |
| ld_ppn | input | PA_W-13 | Physical page number to load |
| ld_size | input | 3 | Page size code to load |
| ld_lock | input | 1 | Lock bit to load |
| ld_cp | input | 1 | Physically-indexed cacheable bit to load |
| ld_cv | input | 1 | Virtually-indexed cacheable bit to load |
| ld_e | input | 1 | Side-effect bit to load |
| ld_soft | input | SOFT_W | Software-defined field (discarded) |
| dg_idx | input | log2(ENTRIES) | Diagnostic slot index |
| dg_we | input | 1 | Diagnostic write strobe |
| dg_wdata | input | DIAG_W | Diagnostic write word |
| dg_rdata | output | DIAG_W | Diagnostic read word |
| rd_idx | input | log2(ENTRIES) | Data-access slot index |
| rd_valid | output | 1 | Stored valid bit |
| rd_lock | output | 1 | Stored lock bit |
| rd_size | output | 3 | Stored size code |
| rd_vpn | output | VA_W-13 | Stored virtual page number |
| rd_ppn | output | PA_W-13 | Stored physical page number, all bits |
| rd_cp | output | 1 | Stored physically-indexed cacheable bit |
| rd_cv | output | 1 | Stored virtually-indexed cacheable bit |
| rd_e | output | 1 | Stored side-effect bit |
| rd_soft | output | SOFT_W | Software-defined field, always 0 |

## Verification
The bench builds the buffer with ENTRIES set to 4 and keeps the default 44-bit virtual and 41-bit physical widths. With four slots, a few loads reach every branch of the replacement policy: the empty-slot pick, the unused-slot pick, the clear-and-retry pick and the all-locked fallback. A short series of loads also gives a slot that is invalid but locked. The same four slots cover all four size codes, an unlisted code, and an overlap where a 4M slot and an 8K slot hit together.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned PG_SHIFT = 13;

  typedef enum logic [2:0] {
    SZ_8K   = 3'b000,
    SZ_64K  = 3'b001,
    SZ_512K = 3'b011,
    SZ_4M   = 3'b111
  } pg_size_e;

  // Number of low page-number bits a size code leaves out of the match.
  function automatic int unsigned size_low_bits(logic [2:0] code);
    case (code)
      SZ_64K:  return 3;
      SZ_512K: return 6;
      SZ_4M:   return 9;
      default: return 0;
    endcase
  endfunction

  // Mask of the ignored page-number bits, as a 64-bit value.
  function automatic logic [63:0] size_mask(logic [2:0] code);
    return (64'd1 << size_low_bits(code)) - 64'd1;
  endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 31
) (
  input  logic [ENTRIES-1:0]            valid_q,
  input  logic [ENTRIES-1:0][2:0]       size_q,
  input  logic [ENTRIES-1:0][VPN_W-1:0] vpn_q,
  input  logic [VPN_W-1:0]              lk_vpn,
  output logic [ENTRIES-1:0]            hit_vec
);
  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_slot
    logic [VPN_W-1:0] cmp_mask;
    logic [VPN_W-1:0] diff;
    assign cmp_mask    = VPN_W'(size_mask(size_q[gi]));
    assign diff        = (vpn_q[gi] ^ lk_vpn) & ~cmp_mask;
    assign hit_vec[gi] = valid_q[gi] && (diff == '0);
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_en,
  input  logic [ENTRIES-1:0] valid_q,
  input  logic [ENTRIES-1:0] lock_q,
  input  logic [ENTRIES-1:0] used_q,
  output logic [IDX_W-1:0]   victim,
  output logic               clear_used
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  function automatic logic [IDX_W-1:0] lowest(logic [ENTRIES-1:0] vec);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (vec[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  logic [ENTRIES-1:0] empty_vec, cold_vec, free_vec;
  logic               all_locked;

  assign empty_vec  = ~valid_q;
  assign free_vec   = ~lock_q;
  assign cold_vec   = ~lock_q & ~used_q;
  assign all_locked = &(valid_q & lock_q);

  always_comb begin
    clear_used = 1'b0;
    if (|empty_vec) begin
      victim = lowest(empty_vec);
    end else if (|cold_vec) begin
      victim = lowest(cold_vec);
    end else if (|free_vec) begin
      victim     = lowest(free_vec);
      clear_used = 1'b1;
    end else begin
      victim = LAST;
    end
  end

  AST_EMPTY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en && !(&valid_q) |-> !valid_q[victim]); // R6
  AST_SKIP_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en && !all_locked |-> !(valid_q[victim] && lock_q[victim])); // R7
  AST_LAST_WHEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en && all_locked |-> victim == LAST); // R9
endmodule

// File: rtl/mpt_tlb.sv
module mpt_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 44,
  parameter int PA_W    = 41,
  parameter int DIAG_W  = 16,
  parameter int SOFT_W  = 15,
  localparam int VPN_W  = VA_W - PG_SHIFT,
  localparam int PPN_W  = PA_W - PG_SHIFT,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VA_W-1:0]   lk_va,
  output logic              lk_hit,
  output logic              lk_multi,
  output logic [PA_W-1:0]   lk_pa,
  output logic              lk_cp,
  output logic              lk_cv,
  output logic              lk_e,
  input  logic              ld_en,
  input  logic              ld_valid,
  input  logic [VPN_W-1:0]  ld_vpn,
  input  logic [PPN_W-1:0]  ld_ppn,
  input  logic [2:0]        ld_size,
  input  logic              ld_lock,
  input  logic              ld_cp,
  input  logic              ld_cv,
  input  logic              ld_e,
  input  logic [SOFT_W-1:0] ld_soft,
  input  logic [IDX_W-1:0]  dg_idx,
  input  logic              dg_we,
  input  logic [DIAG_W-1:0] dg_wdata,
  output logic [DIAG_W-1:0] dg_rdata,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic              rd_lock,
  output logic [2:0]        rd_size,
  output logic [VPN_W-1:0]  rd_vpn,
  output logic [PPN_W-1:0]  rd_ppn,
  output logic              rd_cp,
  output logic              rd_cv,
  output logic              rd_e,
  output logic [SOFT_W-1:0] rd_soft
);
  // Slot state
  logic [ENTRIES-1:0]            valid_q, lock_q, used_q;
  logic [ENTRIES-1:0]            cp_q, cv_q, e_q;
  logic [ENTRIES-1:0][2:0]       size_q;
  logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
  logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;

  // Named internal events
  logic [VPN_W-1:0]   lk_vpn;
  logic [ENTRIES-1:0] hit_vec;
  logic [IDX_W-1:0]   hit_idx;
  logic [IDX_W-1:0]   victim;
  logic               clear_used;
  logic [PPN_W-1:0]   pass_mask;
  logic [PPN_W-1:0]   ppn_merged;
  logic               unused_soft, unused_dg;

  assign lk_vpn      = lk_va[VA_W-1:PG_SHIFT];
  assign unused_soft = ^ld_soft;
  assign unused_dg   = ^dg_wdata[DIAG_W-1:1];

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_match (
    .valid_q (valid_q),
    .size_q  (size_q),
    .vpn_q   (vpn_q),
    .lk_vpn  (lk_vpn),
    .hit_vec (hit_vec)
  );

  tlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_en      (ld_en),
    .valid_q    (valid_q),
    .lock_q     (lock_q),
    .used_q     (used_q),
    .victim     (victim),
    .clear_used (clear_used)
  );

  // Lowest-indexed hit wins
  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end

  assign lk_hit   = |hit_vec;
  assign lk_multi = |(hit_vec & (hit_vec - ENTRIES'(1)));

  assign pass_mask  = PPN_W'(size_mask(size_q[hit_idx]));
  assign ppn_merged = (ppn_q[hit_idx] & ~pass_mask) | (lk_vpn[PPN_W-1:0] & pass_mask);

  assign lk_pa = lk_hit ? {ppn_merged, lk_va[PG_SHIFT-1:0]} : '0;
  assign lk_cp = lk_hit & cp_q[hit_idx];
  assign lk_cv = lk_hit & cv_q[hit_idx];
  assign lk_e  = lk_hit & e_q[hit_idx];

  // Diagnostic view
  always_comb begin
    dg_rdata      = '0;
    dg_rdata[0]   = used_q[dg_idx];
    dg_rdata[3:1] = size_q[dg_idx];
    dg_rdata[6:4] = size_q[dg_idx];
  end

  // Data-access view
  assign rd_valid = valid_q[rd_idx];
  assign rd_lock  = lock_q[rd_idx];
  assign rd_size  = size_q[rd_idx];
  assign rd_vpn   = vpn_q[rd_idx];
  assign rd_ppn   = ppn_q[rd_idx];
  assign rd_cp    = cp_q[rd_idx];
  assign rd_cv    = cv_q[rd_idx];
  assign rd_e     = e_q[rd_idx];
  assign rd_soft  = '0;

  // State update: clear sweep, then hit, then diagnostic, then load
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      lock_q  <= '0;
      used_q  <= '0;
      cp_q    <= '0;
      cv_q    <= '0;
      e_q     <= '0;
      size_q  <= '0;
      vpn_q   <= '0;
      ppn_q   <= '0;
    end else begin
      if (ld_en && clear_used) used_q <= used_q & lock_q;
      if (lk_hit) used_q[hit_idx] <= 1'b1;
      if (dg_we) used_q[dg_idx] <= dg_wdata[0];
      if (ld_en) begin
        valid_q[victim] <= ld_valid;
        lock_q[victim]  <= ld_lock;
        used_q[victim]  <= 1'b1;
        cp_q[victim]    <= ld_cp;
        cv_q[victim]    <= ld_cv;
        e_q[victim]     <= ld_e;
        size_q[victim]  <= ld_size;
        vpn_q[victim]   <= ld_vpn;
        ppn_q[victim]   <= ld_ppn;
      end
    end
  end

  AST_USED_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit && !ld_en && !dg_we |=> used_q[$past(hit_idx)]); // R5
  AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> valid_q[$past(victim)] == $past(ld_valid)); // R6
  AST_MULTI_IMPLIES_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    lk_multi |-> lk_hit); // R4
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_pa[PG_SHIFT-1:0] == lk_va[PG_SHIFT-1:0]); // R3
endmodule

// File: tb/mpt_tlb_tb.sv
`timescale 1ns/1ps
module mpt_tlb_tb;
  localparam int ENTRIES = 4;
  localparam int NV = 10;
  localparam logic [30:0] IDLE_VPN = 31'h7FFF_FFFF;

  // Vector table: lookup page, offset, expected hit, expected slot
  localparam logic [30:0] V_VPN [NV] = '{31'h100, 31'h101, 31'h208, 31'h20F, 31'h210,
                                         31'h4FF, 31'h500, 31'h101FF, 31'h10200, 31'h4C0};
  localparam logic [12:0] V_OFF [NV] = '{13'h123, 13'h5, 13'h0, 13'h1FFF, 13'h10,
                                         13'hABC, 13'h1, 13'h777, 13'h0, 13'h42};
  localparam bit V_HIT [NV] = '{1, 0, 1, 1, 0, 1, 0, 1, 0, 1};
  localparam int V_IDX [NV] = '{0, 0, 1, 1, 0, 2, 0, 3, 0, 2};

  logic clk = 0, rst_n = 0;
  logic [43:0] lk_va;
  logic lk_hit, lk_multi, lk_cp, lk_cv, lk_e;
  logic [40:0] lk_pa;
  logic ld_en, ld_valid, ld_lock, ld_cp, ld_cv, ld_e;
  logic [30:0] ld_vpn;
  logic [27:0] ld_ppn;
  logic [2:0] ld_size;
  logic [14:0] ld_soft;
  logic [1:0] dg_idx, rd_idx;
  logic dg_we;
  logic [15:0] dg_wdata, dg_rdata;
  logic rd_valid, rd_lock, rd_cp, rd_cv, rd_e;
  logic [2:0] rd_size;
  logic [30:0] rd_vpn;
  logic [27:0] rd_ppn;
  logic [14:0] rd_soft;

  int checks = 0, fails = 0;
  logic [27:0] m_ppn [ENTRIES];
  logic [2:0]  m_size [ENTRIES];
  logic [2:0]  m_attr [ENTRIES];

  always #2.5 clk = ~clk;

  mpt_tlb #(.ENTRIES(ENTRIES)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .lk_va(lk_va), .lk_hit(lk_hit), .lk_multi(lk_multi), .lk_pa(lk_pa),
    .lk_cp(lk_cp), .lk_cv(lk_cv), .lk_e(lk_e),
    .ld_en(ld_en), .ld_valid(ld_valid), .ld_vpn(ld_vpn), .ld_ppn(ld_ppn),
    .ld_size(ld_size), .ld_lock(ld_lock), .ld_cp(ld_cp), .ld_cv(ld_cv),
    .ld_e(ld_e), .ld_soft(ld_soft),
    .dg_idx(dg_idx), .dg_we(dg_we), .dg_wdata(dg_wdata), .dg_rdata(dg_rdata),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_lock(rd_lock), .rd_size(rd_size),
    .rd_vpn(rd_vpn), .rd_ppn(rd_ppn), .rd_cp(rd_cp), .rd_cv(rd_cv),
    .rd_e(rd_e), .rd_soft(rd_soft)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected address: drop the ignored bits by shifting, add them back from the page
  function automatic logic [40:0] exp_pa(logic [27:0] ppn, logic [2:0] sz,
                                         logic [30:0] vpn, logic [12:0] off);
    int k;
    logic [27:0] p;
    k = (sz == 3'b001) ? 3 : (sz == 3'b011) ? 6 : (sz == 3'b111) ? 9 : 0;
    p = ((ppn >> k) << k) + 28'(vpn % (31'd1 << k));
    return {p, off};
  endfunction

  task automatic load(input int slot, input bit v, input logic [30:0] vpn,
                      input logic [27:0] ppn, input logic [2:0] sz, input bit lk,
                      input bit cp, input bit cv, input bit e);
    @(negedge clk);
    ld_en = 1; ld_valid = v; ld_vpn = vpn; ld_ppn = ppn; ld_size = sz;
    ld_lock = lk; ld_cp = cp; ld_cv = cv; ld_e = e; ld_soft = '1;
    @(negedge clk);
    ld_en = 0;
    m_ppn[slot] = ppn; m_size[slot] = sz; m_attr[slot] = {cp, cv, e};
  endtask

  task automatic look(input logic [30:0] vpn, input logic [12:0] off);
    @(negedge clk);
    lk_va = {vpn, off};
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    lk_va = {IDLE_VPN, 13'h0};
    #1;
  endtask

  task automatic slot_vpn(input string tag, input int slot, input logic [30:0] exp);
    rd_idx = 2'(slot);
    #1;
    chk(tag, 64'(rd_vpn), 64'(exp));
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    lk_va = {IDLE_VPN, 13'h0};
    ld_en = 0; ld_valid = 0; ld_vpn = 0; ld_ppn = 0; ld_size = 0; ld_lock = 0;
    ld_cp = 0; ld_cv = 0; ld_e = 0; ld_soft = 0;
    dg_idx = 0; dg_we = 0; dg_wdata = 0; rd_idx = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    look(31'h0, 13'h0);
    chk("R1 miss after reset", 64'(lk_hit), 0);
    chk("R1 slot invalid", 64'(rd_valid), 0);
    chk("R1 diag zero", 64'(dg_rdata), 0);

    // Fill the four slots, one of each size (R6: empty slots in order)
    idle();
    load(0, 1, 31'h100,   28'h0AAA, 3'b000, 0, 1, 0, 0);
    load(1, 1, 31'h208,   28'h1237, 3'b001, 0, 1, 1, 0);
    load(2, 1, 31'h4C0,   28'h2015, 3'b011, 0, 0, 0, 1);
    load(3, 1, 31'h10000, 28'h5BFF, 3'b111, 0, 0, 1, 1);
    slot_vpn("R6 first empty slot 0", 0, 31'h100);
    slot_vpn("R6 empty slot 3", 3, 31'h10000);

    // Vector walk: R2 masking, R3 address and attributes
    for (int i = 0; i < NV; i++) begin
      look(V_VPN[i], V_OFF[i]);
      chk("R2 hit", 64'(lk_hit), 64'(V_HIT[i]));
      if (V_HIT[i]) begin
        chk("R3 pa", 64'(lk_pa), 64'(exp_pa(m_ppn[V_IDX[i]], m_size[V_IDX[i]], V_VPN[i], V_OFF[i])));
        chk("R3 attributes", 64'({lk_cp, lk_cv, lk_e}), 64'(m_attr[V_IDX[i]]));
      end else begin
        chk("R3 pa zero on miss", 64'(lk_pa), 0);
      end
    end
    idle();

    // R8: every slot used, none locked -> sweep and take slot 0
    load(0, 1, 31'h301, 28'h0077, 3'b010, 0, 0, 0, 0);
    slot_vpn("R8 sweep takes slot 0", 0, 31'h301);
    dg_idx = 1; #1;
    chk("R8 used cleared on slot 1", 64'(dg_rdata[0]), 0);
    // R2 unlisted code acts as 8K
    look(31'h301, 13'h9);
    chk("R2 unlisted code exact hit", 64'(lk_hit), 1);
    look(31'h300, 13'h9);
    chk("R2 unlisted code neighbour miss", 64'(lk_hit), 0);
    look(31'h208, 13'h0);
    idle();

    // R7: lowest unlocked with used clear
    load(2, 1, 31'h600, 28'h0600, 3'b000, 1, 0, 0, 0);
    slot_vpn("R7 cold slot 2", 2, 31'h600);
    load(3, 1, 31'h601, 28'h0601, 3'b000, 1, 0, 0, 0);
    slot_vpn("R7 cold slot 3", 3, 31'h601);
    load(0, 1, 31'h602, 28'h0222, 3'b000, 1, 1, 0, 1);
    slot_vpn("R8 sweep skips locked", 0, 31'h602);
    load(1, 1, 31'h603, 28'h1ABC, 3'b111, 1, 0, 1, 0);
    slot_vpn("R7 cold slot 1", 1, 31'h603);
    // R9: all locked -> last slot
    load(3, 1, 31'h604, 28'h0604, 3'b000, 0, 0, 0, 0);
    slot_vpn("R9 all locked writes last", 3, 31'h604);
    slot_vpn("R7 locked slot kept", 2, 31'h600);
    // R6: invalid locked slot stays eligible
    load(3, 0, 31'h605, 28'h0605, 3'b000, 1, 0, 0, 0);
    rd_idx = 3; #1;
    chk("R6 invalid load valid bit", 64'(rd_valid), 0);
    load(3, 1, 31'h606, 28'h0606, 3'b000, 0, 0, 0, 0);
    slot_vpn("R6 lock on invalid ignored", 3, 31'h606);
    chk("R6 slot now valid", 64'(rd_valid), 1);

    // R4: overlap of 8K slot 0 and 4M slot 1
    look(31'h602, 13'h55);
    chk("R4 multi flag", 64'(lk_multi), 1);
    chk("R4 hit", 64'(lk_hit), 1);
    chk("R4 lowest slot pa", 64'(lk_pa), 64'({28'h0222, 13'h55}));
    look(31'h7FF, 13'h1);
    chk("R4 single hit no multi", 64'(lk_multi), 0);
    chk("R3 4M pa", 64'(lk_pa), 64'({28'h1BFF, 13'h1}));
    idle();

    // R10 diagnostic access
    @(negedge clk);
    dg_idx = 1; dg_we = 1; dg_wdata = 16'hFFFE;
    @(negedge clk);
    dg_we = 0; #1;
    chk("R10 diag layout used clear", 64'(dg_rdata), 64'h7E);
    // R5 hit sets used
    look(31'h7FF, 13'h0);
    idle();
    chk("R5 used set by hit", 64'(dg_rdata), 64'h7F);
    @(negedge clk);
    dg_we = 1; dg_wdata = 16'h0000;
    @(negedge clk);
    dg_we = 0; #1;
    chk("R10 used written low", 64'(dg_rdata), 64'h7E);

    // R11 data-access read
    rd_idx = 1; #1;
    chk("R11 full ppn", 64'(rd_ppn), 64'h1ABC);
    chk("R11 soft reads zero", 64'(rd_soft), 0);
    chk("R10 size unchanged", 64'(rd_size), 64'h7);
    chk("R11 lock and attributes", 64'({rd_lock, rd_cp, rd_cv, rd_e}), 64'b1010);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule